// File: doc/BRIEF.md
# Multi-port GPIO controller with port-A interrupts

This block is a general-purpose I/O controller for up to four ports, each `W` bits wide. Software reaches it through a simple synchronous register bus: an address, a write strobe, write data, and read data that reflects the addressed register in the same cycle. Each port has a data register and a direction register. A direction bit of 1 turns the pin into an output driven from the data register. The block drives the pad outputs and output enables, and it samples every pad input through a two-flop synchroniser.

Only the first port (port A) can raise interrupts. Each of its bits has its own settings:

- enable and mask;
- type (edge or level) and polarity;
- an optional debounce filter that accepts a new input value only after it has held for `DB_LEN` clock samples.

Edge events stay latched until software acknowledges them by writing ones to a clear register. Level events follow the live input. One combined interrupt line is the OR of all enabled, unmasked status bits.

The bus has no valid/ready handshake. A write takes effect at the clock edge where `bus_we` is high. A read is combinational on `bus_addr`, so there is no back-pressure in either direction. Register addresses are word indices:

| Address | Register |
|---|---|
| `2p` | Data, port p |
| `2p+1` | Direction, port p |
| `8+p` | Synchronised input, port p |
| 12 | Interrupt enable |
| 13 | Mask |
| 14 | Type |
| 15 | Polarity |
| 16 | Debounce enable |
| 17 | Masked status |
| 18 | Raw status |
| 19 | Clear (write-one-to-clear) |

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, every data and direction register reads 0, `pad_oe` is all zero and `irq` is low.
- R2: Writing address `2p` sets port p's data register and writing `2p+1` sets its direction register; both read back as written. `pad_out` carries the data registers and `pad_oe` the direction registers, port p at bits `[p*W +: W]`.
- R3: Reading address `8+p` returns port p's pad inputs after a two-flop synchroniser. A change on the pad is not visible one clock after it and is visible two clocks after it.
- R4: The pad inputs of ports 1 to 3 never change the raw status, the masked status or `irq`.
- R5: With type bit 1 (edge), polarity 1 latches a rising edge and polarity 0 a falling edge of an enabled input bit. The raw status bit (address 18) stays set after the input returns.
- R6: Writing to address 19 clears each latched edge bit written as 1 and leaves bits written as 0 unchanged. Address 19 reads 0.
- R7: With type bit 0 (level), the raw status bit is set while the input equals the polarity bit (1 = high, 0 = low) and clears when it differs. A write to address 19 does not clear it.
- R8: The masked status (address 17) equals raw status with mask bits (address 13) removed. `irq` is high exactly when some masked status bit is set.
- R9: Clearing an enable bit (address 12) clears that bit's latched status, and a disabled bit shows no status.
- R10: A port-A bit whose direction bit is 1 raises no status, whatever its pad does.
- R11: With debounce enabled (address 16), an input change that lasts fewer than `DB_LEN` clocks is ignored, and one that holds longer is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register word address |
| bus_we | input | 1 | Write strobe, one write per cycle high |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data for `bus_addr`, combinational |
| pad_in | input | NP*W | Pad inputs, port p at `[p*W +: W]` |
| pad_out | output | NP*W | Pad output values |
| pad_oe | output | NP*W | Pad output enables (1 = drive) |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with four 8-bit ports and a debounce length of 4. All register addresses therefore exist, and the pins of the non-interrupt ports can be driven to show that they leave the interrupt path alone. The short debounce window puts both the rejected two-cycle pulse and the accepted long hold within a few dozen cycles. One 8-bit port A gives six distinctly configured interrupt bits at once: rising edge, falling edge, active-low level, masked, output-direction and debounced.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int AW = 5;
  localparam int A_EXT  = 8;
  localparam int A_IEN  = 12;
  localparam int A_IMSK = 13;
  localparam int A_ITYP = 14;
  localparam int A_IPOL = 15;
  localparam int A_IDEB = 16;
  localparam int A_STAT = 17;
  localparam int A_RAW  = 18;
  localparam int A_CLR  = 19;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int W      = 8,
  parameter int DB_LEN = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic [W-1:0] en,
  output logic [W-1:0] dout
);
  localparam int CW = $clog2(DB_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(DB_LEN - 1);

  logic [W-1:0]         flt;
  logic [W-1:0][CW-1:0] cnt;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flt[i] <= 1'b0;
        cnt[i] <= '0;
      end else if (!en[i]) begin
        flt[i] <= din[i];
        cnt[i] <= '0;
      end else if (din[i] == flt[i]) begin
        cnt[i] <= '0;
      end else if (cnt[i] == LAST) begin
        flt[i] <= din[i];
        cnt[i] <= '0;
      end else begin
        cnt[i] <= cnt[i] + 1'b1;
      end
    end

    assign dout[i] = en[i] ? flt[i] : din[i];

    // the filtered value moves only at the end of a full window
    assert_deb_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en[i]) && (flt[i] != $past(flt[i]))) |-> ($past(cnt[i]) == LAST));
  end
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic [W-1:0] en,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] typ,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] clr,
  output logic [W-1:0] raw
);
  logic [W-1:0] prev;
  logic [W-1:0] lat;
  logic [W-1:0] evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= src;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign evt[i] = typ[i] & ~dir[i] &
                    (pol[i] ? (src[i] & ~prev[i]) : (~src[i] & prev[i]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                lat[i] <= 1'b0;
      else if (!en[i] || !typ[i]) lat[i] <= 1'b0;
      else if (evt[i])           lat[i] <= 1'b1;
      else if (clr[i])           lat[i] <= 1'b0;
    end

    assign raw[i] = typ[i] ? lat[i]
                           : (en[i] & ~dir[i] & (src[i] == pol[i]));

    assert_edge_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (lat[i] && en[i] && typ[i] && !clr[i]) |=> lat[i]);

    assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !en[i] |=> !lat[i]);

    assert_output_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (dir[i] && !lat[i]) |=> !lat[i]);
  end
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int NP     = 4,
  parameter int W      = 8,
  parameter int DB_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_we,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [NP*W-1:0]   pad_in,
  output logic [NP*W-1:0]   pad_out,
  output logic [NP*W-1:0]   pad_oe,
  output logic              irq
);
  logic [NP-1:0][W-1:0] dat_q, dir_q;
  logic [W-1:0] ien, imsk, ityp, ipol, ideb;
  logic [W-1:0] clr, pin_f, raw, stat;
  logic [NP*W-1:0] pin_s;

  for (genvar p = 0; p < NP; p++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dat_q[p] <= '0;
        dir_q[p] <= '0;
      end else if (bus_we) begin
        if (bus_addr == AW'(2 * p))     dat_q[p] <= bus_wdata;
        if (bus_addr == AW'(2 * p + 1)) dir_q[p] <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien  <= '0;
      imsk <= '0;
      ityp <= '0;
      ipol <= '0;
      ideb <= '0;
    end else if (bus_we) begin
      if (bus_addr == AW'(A_IEN))  ien  <= bus_wdata;
      if (bus_addr == AW'(A_IMSK)) imsk <= bus_wdata;
      if (bus_addr == AW'(A_ITYP)) ityp <= bus_wdata;
      if (bus_addr == AW'(A_IPOL)) ipol <= bus_wdata;
      if (bus_addr == AW'(A_IDEB)) ideb <= bus_wdata;
    end
  end

  assign clr = (bus_we && bus_addr == AW'(A_CLR)) ? bus_wdata : '0;

  gpio_sync #(.N(NP * W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_s)
  );

  gpio_debounce #(.W(W), .DB_LEN(DB_LEN)) u_deb (
    .clk(clk), .rst_n(rst_n), .din(pin_s[W-1:0]), .en(ideb), .dout(pin_f)
  );

  gpio_irq #(.W(W)) u_irq (
    .clk(clk), .rst_n(rst_n), .src(pin_f), .en(ien), .dir(dir_q[0]),
    .typ(ityp), .pol(ipol), .clr(clr), .raw(raw)
  );

  assign stat    = raw & ~imsk;
  assign irq     = |stat;
  assign pad_out = dat_q;
  assign pad_oe  = dir_q;

  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NP; p++) begin
      if (bus_addr == AW'(2 * p))     bus_rdata = dat_q[p];
      if (bus_addr == AW'(2 * p + 1)) bus_rdata = dir_q[p];
      if (bus_addr == AW'(A_EXT + p)) bus_rdata = pin_s[p*W +: W];
    end
    if (bus_addr == AW'(A_IEN))  bus_rdata = ien;
    if (bus_addr == AW'(A_IMSK)) bus_rdata = imsk;
    if (bus_addr == AW'(A_ITYP)) bus_rdata = ityp;
    if (bus_addr == AW'(A_IPOL)) bus_rdata = ipol;
    if (bus_addr == AW'(A_IDEB)) bus_rdata = ideb;
    if (bus_addr == AW'(A_STAT)) bus_rdata = stat;
    if (bus_addr == AW'(A_RAW))  bus_rdata = raw;
  end

  // a cycle held in reset leaves every pin an input and the line quiet
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (pad_oe == '0 && !irq));

  // pins of ports beyond A cannot move the combined line on their own
  assert_upper_ports_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(pin_s[W-1:0]) && $stable(ien) && $stable(imsk) && $stable(ityp) &&
     $stable(ipol) && $stable(dir_q[0]) && !irq && $past(clr) == '0 && $past(!bus_we))
    |=> !irq || $changed(raw));
endmodule

// File: tb/sim_gpio_ctrl.sv
module sim_gpio_ctrl;
  import gpio_pkg::*;

  localparam int NP = 4;
  localparam int W  = 8;
  localparam int DB = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [AW-1:0]     bus_addr = '0;
  logic              bus_we = 1'b0;
  logic [W-1:0]      bus_wdata = '0;
  logic [W-1:0]      bus_rdata;
  logic [NP*W-1:0]   pad_in = '0;
  logic [NP*W-1:0]   pad_out;
  logic [NP*W-1:0]   pad_oe;
  logic              irq;

  int total = 0;
  int bad   = 0;
  logic rd_v = 1'b0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #10 clk = ~clk;

  gpio_ctrl #(.NP(NP), .W(W), .DB_LEN(DB)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected item for each read presented on the bus
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (rd_v) begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, 32'(bus_rdata), 32'(e));
      end
    end
  end

  task automatic wr(input int a, input logic [W-1:0] d);
    @(negedge clk);
    bus_addr = AW'(a);
    bus_wdata = d;
    bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, input logic [W-1:0] e, input string t);
    @(negedge clk);
    bus_addr = AW'(a);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_v = 1'b1;
    @(negedge clk);
    rd_v = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk("R1 pad_oe", 32'(pad_oe), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    rd(0, 8'h00, "R1 data port0");
    rd(7, 8'h00, "R1 dir port3");

    // R2 data/direction and pads
    wr(2, 8'hA5);
    wr(3, 8'hF0);
    rd(2, 8'hA5, "R2 data port1");
    rd(3, 8'hF0, "R2 dir port1");
    @(negedge clk);
    chk("R2 pad_out port1", 32'(pad_out[15:8]), 32'hA5);
    chk("R2 pad_oe port1", 32'(pad_oe[15:8]), 32'hF0);

    // R3 synchroniser latency
    @(negedge clk);
    pad_in[23:16] = 8'h3C;
    rd(A_EXT + 2, 8'h00, "R3 one clock");
    rd(A_EXT + 2, 8'h3C, "R3 two clocks");

    // port A interrupt setup: bits 0,1,3,4,5 edge, bit2 level
    wr(A_ITYP, 8'h3B);
    wr(A_IPOL, 8'h39);
    wr(A_IDEB, 8'h20);
    wr(1, 8'h10);
    @(negedge clk);
    pad_in[7:0] = 8'h06;
    settle();
    wr(A_IEN, 8'h3F);
    settle();
    rd(A_RAW, 8'h00, "R9 baseline raw");
    chk("R8 irq idle", 32'(irq), 32'h0);

    // R5 rising edge, R6 selective clear
    pad_in[0] = 1'b1;
    settle();
    rd(A_RAW, 8'h01, "R5 rising latched");
    rd(A_STAT, 8'h01, "R8 status unmasked");
    chk("R8 irq on", 32'(irq), 32'h1);
    pad_in[0] = 1'b0;
    settle();
    rd(A_RAW, 8'h01, "R5 held after fall");
    wr(A_CLR, 8'h02);
    rd(A_RAW, 8'h01, "R6 zero bits untouched");
    wr(A_CLR, 8'h01);
    rd(A_RAW, 8'h00, "R6 one clears");
    @(negedge clk);
    chk("R8 irq off", 32'(irq), 32'h0);
    rd(A_CLR, 8'h00, "R6 reads zero");

    // R5 falling edge
    pad_in[1] = 1'b0;
    settle();
    rd(A_RAW, 8'h02, "R5 falling latched");
    wr(A_CLR, 8'h02);
    rd(A_RAW, 8'h00, "R6 falling cleared");

    // R7 level active-low
    pad_in[2] = 1'b0;
    settle();
    rd(A_RAW, 8'h04, "R7 level asserted");
    wr(A_CLR, 8'h04);
    rd(A_RAW, 8'h04, "R7 clear ignored");
    pad_in[2] = 1'b1;
    settle();
    rd(A_RAW, 8'h00, "R7 level released");

    // R8 mask, R9 disable
    wr(A_IMSK, 8'h08);
    pad_in[3] = 1'b1;
    settle();
    rd(A_RAW, 8'h08, "R8 raw shows masked");
    rd(A_STAT, 8'h00, "R8 status hides masked");
    chk("R8 irq masked", 32'(irq), 32'h0);
    wr(A_IEN, 8'h37);
    rd(A_RAW, 8'h00, "R9 disable clears");
    pad_in[3] = 1'b0;

    // R10 output pin ignored
    pad_in[4] = 1'b1;
    settle();
    pad_in[4] = 1'b0;
    settle();
    rd(A_RAW, 8'h00, "R10 output pin");

    // R11 debounce
    pad_in[5] = 1'b1;
    repeat (2) @(negedge clk);
    pad_in[5] = 1'b0;
    repeat (10) @(negedge clk);
    rd(A_RAW, 8'h00, "R11 short pulse rejected");
    pad_in[5] = 1'b1;
    repeat (3) @(negedge clk);
    rd(A_RAW, 8'h00, "R11 inside window");
    repeat (10) @(negedge clk);
    rd(A_RAW, 8'h20, "R11 long hold accepted");
    rd(A_STAT, 8'h20, "R8 debounced status");

    // R4 other ports do not interrupt
    wr(A_CLR, 8'h20);
    rd(A_RAW, 8'h00, "R4 cleared before");
    pad_in[31:8] = '1;
    settle();
    pad_in[31:8] = '0;
    settle();
    pad_in[31:8] = '1;
    settle();
    rd(A_RAW, 8'h00, "R4 raw unchanged");
    chk("R4 irq quiet", 32'(irq), 32'h0);
    rd(A_EXT + 3, 8'hFF, "R3 port3 input");

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule